// File: doc/BRIEF.md
# Maskable Interrupt Event Controller

This block gathers single-cycle event strobes from surrounding logic into a 24-bit status register. It qualifies those bits with a 24-bit enable mask and produces one interrupt pin. Software clears handled events by writing ones to the status bits it has serviced. A set strobe always wins over a clear in the same cycle. Because of this, a handler that reads status and later writes the same value back cannot lose an event that arrived in between.

The pin has four output formats, chosen by two configuration inputs. The pin can be a level or a pulse, and either active-low or active-high. Pulse timing counts periods of a divided-clock enable input, not raw clock cycles. Each pulse therefore lasts exactly one divided-clock period. Both registers can be read back on dedicated outputs.

Top module: `irq_event_ctrl`

## Requirements
- R1: After reset the status and mask read back as zero and `irq_o` is 1, the inactive level for level format with no inversion.
- R2: A 1 on any `event_i` bit sets the matching status bit on that clock edge, whatever the mask holds.
- R3: A status write clears each bit whose `wr_data_i` bit is 1 and leaves bits written with 0 unchanged. A write of 0xFFFFFF clears all bits.
- R4: When an event strobe and a status clear hit the same bit in the same cycle, the bit ends set. A value read from status and written back therefore keeps an event that arrived after the read.
- R5: A mask write loads `wr_data_i` into the mask. Without a mask write the mask holds its value.
- R6: In level format (`out_pulse_i`=0), the pin is active whenever status AND mask is nonzero. It changes in the same cycle as the register that caused the change.
- R7: A status bit whose mask bit is 0 never makes the pin active, in either format.
- R8: In pulse format (`out_pulse_i`=1), a masked status bit going from 0 to 1 starts a pulse at the next `div_tick_i` cycle. The pulse lasts until the following `div_tick_i`, exactly one tick period.
- R9: The active level follows `out_invert_i`: 0 gives an active-low pin (low level or low pulse), 1 gives an active-high pin.
- R10: All rising transitions seen before a pulse starts share that one pulse. A transition during a pulse produces one more pulse, after a gap of at least one tick period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| div_tick_i | input | 1 | One-cycle enable marking each divided-clock period |
| event_i | input | 24 | Event strobes, one per status bit |
| stat_clr_wr_i | input | 1 | Status write strobe (write-one-to-clear) |
| mask_wr_i | input | 1 | Mask write strobe |
| wr_data_i | input | 24 | Write data for status or mask |
| out_pulse_i | input | 1 | Output format: 0 level, 1 pulse |
| out_invert_i | input | 1 | Output polarity: 0 active-low, 1 active-high |
| stat_o | output | 24 | Status read-back |
| mask_o | output | 24 | Mask read-back |
| irq_o | output | 1 | Interrupt pin |

## Verification
A wrong status bit shows on `stat_o` one edge after the faulty strobe or write. In level format it also shows on `irq_o` in the same cycle. A lost edge or stuck pending flag in the pulse logic only appears at the next divided-clock tick. It appears as a missing, extra or wrongly sized pulse. Pulse width and the count of pulses are therefore measured over whole windows, and these measurements are combined with a comparison against a reference on every clock.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  parameter int unsigned EVT_W = 24;

  typedef enum logic {
    OUT_LEVEL = 1'b0,
    OUT_PULSE = 1'b1
  } out_fmt_e;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/irqc_status_reg.sv
module irqc_status_reg #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] event_i,
  input  logic         clr_wr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q, stat_d, clr_vec;

  // set has priority over clear, bit by bit
  always_comb begin
    clr_vec = clr_wr_i ? wr_data_i : '0;
    stat_d  = (stat_q & ~clr_vec) | event_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  assert_evt_sets_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (event_i != '0) |=> ((stat_q & $past(event_i)) == $past(event_i)));

  assert_idle_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_wr_i && event_i == '0) |=> $stable(stat_q));

  assert_clear_unless_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr_i |=> ((stat_q & $past(wr_data_i) & ~$past(event_i)) == '0));
endmodule

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         wr_i,
  input  logic [W-1:0] wr_data_i,
  output logic [W-1:0] mask_o
);
  logic [W-1:0] mask_q, mask_d;

  always_comb begin
    mask_d = wr_i ? wr_data_i : mask_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mask_q <= '0;
    else         mask_q <= mask_d;
  end

  assign mask_o = mask_q;

  assert_mask_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(mask_q));

  assert_mask_load_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (mask_q == $past(wr_data_i)));
endmodule

// File: rtl/irqc_out_gen.sv
module irqc_out_gen
  import irqc_pkg::*;
#(
  parameter int unsigned W = 24
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  out_fmt_e     fmt_i,
  input  logic         invert_i,
  input  logic [W-1:0] stat_i,
  input  logic [W-1:0] mask_i,
  output logic         irq_o
);
  logic [W-1:0] masked, rise, prev_q, prev_d;
  logic         pend_q, pend_d, pulse_q, pulse_d;
  logic         any_edge, start, active;

  always_comb begin
    masked   = stat_i & mask_i;
    rise     = masked & ~prev_q;
    any_edge = pend_q | (|rise);
    start    = tick_i & ~pulse_q & any_edge;
    prev_d   = masked;
    if (fmt_i == OUT_LEVEL) begin
      pend_d  = 1'b0;
      pulse_d = 1'b0;
    end else if (start) begin
      pend_d  = 1'b0;
      pulse_d = 1'b1;
    end else begin
      pend_d  = any_edge;
      pulse_d = tick_i ? 1'b0 : pulse_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= '0;
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      pend_q  <= pend_d;
      pulse_q <= pulse_d;
    end
  end

  always_comb begin
    active = (fmt_i == OUT_PULSE) ? pulse_q : (|masked);
    irq_o  = ~(active ^ invert_i);
  end

  assert_pulse_waits_tick_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulse_q && !tick_i) |=> !pulse_q);

  assert_pulse_holds_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q && !tick_i && fmt_i == OUT_PULSE) |=> pulse_q);

  assert_pulse_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_q && tick_i) |=> !pulse_q);

  assert_level_idle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fmt_i == OUT_LEVEL) |=> (!pulse_q && !pend_q));
endmodule

// File: rtl/irq_event_ctrl.sv
module irq_event_ctrl
  import irqc_pkg::*;
#(
  parameter int unsigned N_EVT = EVT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             div_tick_i,
  input  logic [N_EVT-1:0] event_i,
  input  logic             stat_clr_wr_i,
  input  logic             mask_wr_i,
  input  logic [N_EVT-1:0] wr_data_i,
  input  logic             out_pulse_i,
  input  logic             out_invert_i,
  output logic [N_EVT-1:0] stat_o,
  output logic [N_EVT-1:0] mask_o,
  output logic             irq_o
);
  logic     rst_n_s;
  out_fmt_e fmt;

  assign fmt = out_fmt_e'(out_pulse_i);

  irqc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .rst_no(rst_n_s)
  );

  irqc_status_reg #(.W(N_EVT)) i_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .event_i  (event_i),
    .clr_wr_i (stat_clr_wr_i),
    .wr_data_i(wr_data_i),
    .stat_o   (stat_o)
  );

  irqc_mask_reg #(.W(N_EVT)) i_mask (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .wr_i     (mask_wr_i),
    .wr_data_i(wr_data_i),
    .mask_o   (mask_o)
  );

  irqc_out_gen #(.W(N_EVT)) i_out (
    .clk_i   (clk_i),
    .rst_ni  (rst_n_s),
    .tick_i  (div_tick_i),
    .fmt_i   (fmt),
    .invert_i(out_invert_i),
    .stat_i  (stat_o),
    .mask_i  (mask_o),
    .irq_o   (irq_o)
  );

  assert_masked_off_R7: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (mask_o == '0 && fmt == OUT_LEVEL) |-> (irq_o == ~out_invert_i));
endmodule

// File: tb/test_irq_event_ctrl.sv
module test_irq_event_ctrl;
  localparam int W = 24;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic [W-1:0] evt = '0;
  logic         swr = 1'b0;
  logic         mwr = 1'b0;
  logic [W-1:0] wdata = '0;
  logic         fmt_p = 1'b0;
  logic         inv = 1'b0;
  logic [W-1:0] stat, mask;
  logic         irq;

  int nchk = 0, nerr = 0, cyc = 0, tdiv = 4, tcnt = 0;
  bit cmp_en = 1'b0;

  always #2 clk = ~clk;

  irq_event_ctrl i_irq_event_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .div_tick_i(tick), .event_i(evt),
    .stat_clr_wr_i(swr), .mask_wr_i(mwr), .wr_data_i(wdata),
    .out_pulse_i(fmt_p), .out_invert_i(inv),
    .stat_o(stat), .mask_o(mask), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // divided-clock enable, driven 1 ns after each edge
  always @(posedge clk) begin
    #1;
    tcnt = (tcnt + 1 >= tdiv) ? 0 : tcnt + 1;
    tick = (tcnt == 0);
  end

  // reference model
  logic [W-1:0] m_stat = '0, m_mask = '0, m_prev = '0, mk, rs, cl;
  bit m_pend = 0, m_pulse = 0, any;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_stat = '0; m_mask = '0; m_prev = '0; m_pend = 0; m_pulse = 0;
    end else begin
      mk  = m_stat & m_mask;
      rs  = mk & ~m_prev;
      any = m_pend || (rs != '0);
      if (!fmt_p) begin
        m_pend = 0; m_pulse = 0;
      end else if (tick && !m_pulse && any) begin
        m_pulse = 1; m_pend = 0;
      end else begin
        m_pend = any;
        if (tick) m_pulse = 0;
      end
      m_prev = mk;
      cl = swr ? wdata : '0;
      m_stat = (m_stat & ~cl) | evt;
      if (mwr) m_mask = wdata;
    end
  end

  function automatic logic exp_irq();
    logic act;
    act = fmt_p ? m_pulse : ((m_stat & m_mask) != '0);
    return inv ? act : ~act;
  endfunction

  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R3 status vs model", stat, m_stat);
      chk("R5 mask vs model", mask, m_mask);
      chk("R6 irq vs model", irq, exp_irq());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nerr++; nchk++;
      $display("FAIL watchdog R8 actual=%0d expected=<100000", cyc);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
    evt = '0; swr = 1'b0; mwr = 1'b0;
  endtask

  task automatic fire(input logic [W-1:0] e);
    @(posedge clk); #1;
    evt = e; swr = 1'b0; mwr = 1'b0;
    step();
  endtask

  task automatic wr_stat(input logic [W-1:0] d, input logic [W-1:0] e);
    @(posedge clk); #1;
    swr = 1'b1; wdata = d; evt = e; mwr = 1'b0;
    step();
  endtask

  task automatic wr_mask(input logic [W-1:0] d);
    @(posedge clk); #1;
    mwr = 1'b1; wdata = d; swr = 1'b0; evt = '0;
    step();
  endtask

  // counts active cycles and pulses over n cycles; optional second event once active
  task automatic window(input int n, input logic [W-1:0] late_evt,
                        output int act_cyc, output int pulses);
    bit was = 0, fired = 0, now;
    act_cyc = 0; pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      now = (irq == inv);
      if (now) act_cyc++;
      if (now && !was) pulses++;
      was = now;
      @(posedge clk); #1;
      evt = '0;
      if (now && !fired && late_evt != '0) begin
        evt = late_evt; fired = 1;
      end
    end
    step();
  endtask

  logic [W-1:0] rd;
  int ac, np;

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) step();
    @(negedge clk);
    chk("R1 reset status", stat, 0);
    chk("R1 reset mask", mask, 0);
    chk("R1 reset irq", irq, 1);
    cmp_en = 1'b1;

    fire(24'h000021);
    @(negedge clk);
    chk("R2 events set status unmasked", stat, 24'h000021);
    chk("R7 unmasked bits leave irq idle", irq, 1);

    wr_mask(24'h000001);
    @(negedge clk);
    chk("R5 mask read-back", mask, 24'h000001);
    chk("R6 active-low level", irq, 0);
    step(); inv = 1'b1;
    @(negedge clk);
    chk("R9 active-high level", irq, 1);

    wr_stat(24'h000020, '0);
    @(negedge clk);
    chk("R3 one clears, zero keeps", stat, 24'h000001);
    wr_stat(24'h000000, '0);
    @(negedge clk);
    chk("R3 write of zero no change", stat, 24'h000001);

    wr_stat(24'h000008, 24'h000008);
    @(negedge clk);
    chk("R4 set wins same cycle", stat, 24'h000009);
    rd = stat;
    fire(24'h000080);
    wr_stat(rd, '0);
    @(negedge clk);
    chk("R4 late event survives write-back", stat, 24'h000080);

    wr_stat(24'hFFFFFF, '0);
    @(negedge clk);
    chk("R3 all-ones clears all", stat, 0);
    chk("R6 irq idle when clear", irq, 0);

    // pulse format, active-low
    step(); inv = 1'b0; fmt_p = 1'b1;
    wr_mask(24'hFFFFFF);
    repeat (3) step();
    fire(24'h000004);
    window(24, '0, ac, np);
    chk("R8 pulse width one tick", ac, tdiv);
    chk("R9 single low pulse", np, 1);

    fire(24'h000018);
    window(24, '0, ac, np);
    chk("R10 same-window edges share pulse", np, 1);

    fire(24'h000040);
    window(40, 24'h000800, ac, np);
    chk("R10 edge during pulse gives second", np, 2);
    chk("R8 two pulses width", ac, 2 * tdiv);

    // active-high pulse, other divider
    wr_stat(24'hFFFFFF, '0);
    step(); inv = 1'b1; tdiv = 3;
    repeat (4) step();
    fire(24'h100000);
    window(24, '0, ac, np);
    chk("R9 high pulse count", np, 1);
    chk("R8 high pulse width", ac, 3);

    wr_mask(24'h000000);
    fire(24'h200000);
    window(12, '0, ac, np);
    chk("R7 masked-off event no pulse", np, 0);

    repeat (2) step();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule